// File: doc/BRIEF.md
# Temperature-Sensor Bias and Input Sequencer

This block drives the switches of a bipolar-transistor temperature-sensor front end. Its pace is set by a half-cycle strobe. Every second strobe opens a new modulator cycle, and on that strobe the block samples the analog modulator's output bit. For the two halves of the cycle it then produces four kinds of registered control: enables that connect each of six unit current sources to a left or a right transistor, a swap line that exchanges the two transistors' biasing at mid-cycle, a select for the modulator's input multiplexer, and the dither bit used for fine trim.

When the sampled bit is zero, the block steers the sources into a 5:1 ratio and selects the gain-of-16 difference voltage. The source that carries the single unit current rotates among the six, one step per zero-cycle. When the bit is one, the block biases one transistor at a time and selects that transistor's base-emitter voltage. A coarse setting switches on up to five fixed sources. The sixth source is gated by the carry of an 8-bit first-order digital sigma-delta accumulator. That accumulator steps only in one-cycles and holds its state through zero-cycles, so the trim dither cannot mix with the main bitstream.

Top module: `tsense_seq`

## Requirements
- R1: Synchronous reset clears every output to zero: both enable vectors 0, swap 0, select 0 (difference input), trim bit 0. It also clears the rotation index and the trim accumulator.
- R2: Every strobe toggles swap. Swap is 1 for the first half of each modulator cycle and 0 for the second half.
- R3: In a zero-cycle the select is 0. In the first half the unit source is the only left enable and the other five are right enables. In the second half the two vectors are exchanged.
- R4: The unit source index begins at 0 after reset. It advances by one, modulo 6, after each zero-cycle, and one-cycles leave it unchanged. Over any six consecutive zero-cycles, each source is the unit source exactly once.
- R5: In a one-cycle the select is 1 (left base-emitter voltage) in the first half and 2 (right base-emitter voltage) in the second half. The transistor that is not selected has all enables 0.
- R6: In a one-cycle, sources 0 to k-1 are enabled and sources k to 4 are disabled, where k is the coarse input clamped to at most 5.
- R7: Source 5 is enabled in a one-cycle exactly when the trim bit is 1. The trim bit is the carry out of adding the 8-bit trim code to the 8-bit accumulator, and it stays the same in both halves of the cycle. Starting from a cleared accumulator, 256 one-cycles produce exactly code trim bits equal to 1.
- R8: The trim accumulator keeps its state through zero-cycles, and the trim bit is 0 in those cycles. After any zero-cycles are inserted, the sequence of trim bits carries on as if they had not occurred.
- R9: The bitstream input is sampled only on the first strobe of a cycle. Its value on the mid-cycle strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Half-cycle strobe; outputs update on clocks where it is high |
| bs | input | 1 | Modulator bitstream bit, sampled at cycle start |
| trim_code | input | 8 | Fine trim code, 1/256 unit per step |
| coarse | input | 3 | Number of fixed-on sources in one-cycles (clamped to 5) |
| src_left | output | 6 | Source enables toward the left transistor |
| src_right | output | 6 | Source enables toward the right transistor |
| swap | output | 1 | Half-cycle swap control |
| mux_sel | output | 2 | Input select: 0 difference, 1 left VBE, 2 right VBE |
| trim_bit | output | 1 | Dither bit applied to source 5 this cycle |

## Verification
A run of back-to-back zero-cycles reveals a rotation that skips, repeats or fails to wrap. Inserting one-cycles between zero-cycles shows whether the index wrongly advances during those one-cycles. A long run of one-cycles at a fixed code measures the trim duty against code/256. Interleaving zero-cycles into that run separates a frozen accumulator from one that keeps counting. A sweep of coarse values from 0 to 7 tests the clamp. Flipping the bit on the mid-cycle strobe shows whether the bit is sampled anywhere other than at the start of a cycle.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  typedef enum logic [1:0] {
    SEL_DIFF  = 2'd0,
    SEL_VBE_L = 2'd1,
    SEL_VBE_R = 2'd2
  } sel_e;
endpackage

// File: rtl/tsense_phase.sv
module tsense_phase (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic bs,
  output logic start,
  output logic bs_cur
);
  // ph_q = 1: the next strobe opens a new modulator cycle
  logic ph_q;
  logic bs_q;

  assign start  = tick & ph_q;
  assign bs_cur = start ? bs : bs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= 1'b1;
      bs_q <= 1'b0;
    end else if (tick) begin
      ph_q <= ~ph_q;
      if (ph_q) bs_q <= bs;
    end
  end

  // R9: the held bit cannot change on a mid-cycle strobe
  p_bs_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && !ph_q) |=> (bs_q == $past(bs_q)));
endmodule

// File: rtl/tsense_dem_ptr.sv
module tsense_dem_ptr #(
  parameter int N_SRC = 6,
  localparam int PW = $clog2(N_SRC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(N_SRC - 1);

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  p_ptr_range_r4: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr));
endmodule

// File: rtl/tsense_trim_dsm.sv
module tsense_trim_dsm #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] code,
  output logic         carry
);
  logic [W-1:0] acc_q;
  logic [W-1:0] sum;

  assign {carry, sum} = {1'b0, acc_q} + {1'b0, code};

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (adv) acc_q <= sum;
  end

  // R8: accumulator is frozen whenever it is not advanced
  p_trim_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(acc_q));
endmodule

// File: rtl/tsense_steer.sv
module tsense_steer
  import tsense_pkg::*;
#(
  parameter int N_SRC = 6,
  parameter int CW    = 3,
  localparam int PW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic             bs_cur,
  input  logic [PW-1:0]    unit,
  input  logic             carry,
  input  logic [CW-1:0]    coarse,
  output logic [N_SRC-1:0] src_left,
  output logic [N_SRC-1:0] src_right,
  output logic             swap,
  output logic [1:0]       mux_sel,
  output logic             trim_bit
);
  localparam logic [CW-1:0] KMAX = CW'(N_SRC - 1);

  logic [CW-1:0]    kcl;
  logic [N_SRC-1:0] stat_mask, bias_mask, unit_oh, mask_cur, mask_q;
  logic [N_SRC-1:0] l_d, r_d;
  sel_e             sel_d;

  assign kcl = (coarse > KMAX) ? KMAX : coarse;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign unit_oh[i] = (unit == PW'(i));
    if (i < N_SRC - 1) begin : g_stat
      assign stat_mask[i] = (CW'(i) < kcl);
      assign bias_mask[i] = stat_mask[i];
    end else begin : g_trim
      assign stat_mask[i] = 1'b0;
      assign bias_mask[i] = carry;
    end
  end

  assign mask_cur = start ? (bs_cur ? bias_mask : unit_oh) : mask_q;

  always_comb begin
    if (!bs_cur) begin
      sel_d = SEL_DIFF;
      l_d   = start ? mask_cur : ~mask_cur;
      r_d   = start ? ~mask_cur : mask_cur;
    end else begin
      sel_d = start ? SEL_VBE_L : SEL_VBE_R;
      l_d   = start ? mask_cur : '0;
      r_d   = start ? '0 : mask_cur;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_left  <= '0;
      src_right <= '0;
      swap      <= 1'b0;
      mux_sel   <= SEL_DIFF;
      trim_bit  <= 1'b0;
      mask_q    <= '0;
    end else if (tick) begin
      src_left  <= l_d;
      src_right <= r_d;
      swap      <= start;
      mux_sel   <= sel_d;
      trim_bit  <= bs_cur & mask_cur[N_SRC-1];
      if (start) mask_q <= mask_cur;
    end
  end

  p_swap_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> (swap != $past(swap)));
  p_disjoint_r3: assert property (@(posedge clk) disable iff (rst)
    (src_left & src_right) == '0);
  p_ratio_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !bs_cur) |=> ((src_left | src_right) == '1 &&
      ($countones(src_left) == 1 || $countones(src_right) == 1)));
  p_vbe_side_r5: assert property (@(posedge clk) disable iff (rst)
    (mux_sel == SEL_VBE_L) |-> (swap && src_right == '0));
  p_trim_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (mux_sel == SEL_DIFF) |-> !trim_bit);
endmodule

// File: rtl/tsense_seq.sv
module tsense_seq #(
  parameter int N_SRC  = 6,
  parameter int TRIM_W = 8,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bs,
  input  logic [TRIM_W-1:0] trim_code,
  input  logic [CW-1:0]     coarse,
  output logic [N_SRC-1:0]  src_left,
  output logic [N_SRC-1:0]  src_right,
  output logic              swap,
  output logic [1:0]        mux_sel,
  output logic              trim_bit
);
  localparam int PW = $clog2(N_SRC);

  logic          start, bs_cur, carry;
  logic [PW-1:0] unit;

  tsense_phase u_phase (
    .clk(clk), .rst(rst), .tick(tick), .bs(bs),
    .start(start), .bs_cur(bs_cur)
  );

  tsense_dem_ptr #(.N_SRC(N_SRC)) u_ptr (
    .clk(clk), .rst(rst), .adv(start & ~bs_cur), .ptr(unit)
  );

  tsense_trim_dsm #(.W(TRIM_W)) u_trim (
    .clk(clk), .rst(rst), .adv(start & bs_cur), .code(trim_code),
    .carry(carry)
  );

  tsense_steer #(.N_SRC(N_SRC), .CW(CW)) u_steer (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .bs_cur(bs_cur),
    .unit(unit), .carry(carry), .coarse(coarse),
    .src_left(src_left), .src_right(src_right), .swap(swap),
    .mux_sel(mux_sel), .trim_bit(trim_bit)
  );
endmodule

// File: tb/tsense_seq_tb.sv
module tsense_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       bs = 1'b0;
  logic [7:0] trim_code = '0;
  logic [2:0] coarse = '0;
  logic [5:0] src_left, src_right;
  logic       swap, trim_bit;
  logic [1:0] mux_sel;

  int checks = 0;
  int errors = 0;
  int m_ptr = 0;
  int m_acc = 0;
  int last_trim = 0;
  int last_unit = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsense_seq u_dut (
    .clk(clk), .rst(rst), .tick(tick), .bs(bs), .trim_code(trim_code),
    .coarse(coarse), .src_left(src_left), .src_right(src_right),
    .swap(swap), .mux_sel(mux_sel), .trim_bit(trim_bit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic half(input bit b);
    @(negedge clk);
    tick = 1'b1;
    bs   = b;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // one modulator cycle; b2 is driven on the mid-cycle strobe (R9)
  task automatic run_cycle(input bit b, input bit b2, input string tag);
    int k, s, c;
    logic [5:0] m;
    if (b == 1'b0) begin
      m = 6'(1 << m_ptr);
      last_unit = m_ptr;
      last_trim = 0;
      half(b);
      chk(swap == 1'b1, "R2", {tag, " swap h1"}, swap, 1);
      chk(mux_sel == 2'd0, "R3", {tag, " sel h1"}, mux_sel, 0);
      chk(src_left == m && src_right == ~m, "R3", {tag, " left h1"},
          {src_left, src_right}, {m, ~m});
      chk(trim_bit == 1'b0, "R8", {tag, " trim in zero-cycle"}, trim_bit, 0);
      half(b2);
      chk(swap == 1'b0, "R2", {tag, " swap h2"}, swap, 0);
      chk(mux_sel == 2'd0, "R9", {tag, " sel h2"}, mux_sel, 0);
      chk(src_left == ~m && src_right == m, "R3", {tag, " exch h2"},
          {src_left, src_right}, {~m, m});
      m_ptr = (m_ptr + 1) % 6;
    end else begin
      k = (coarse > 3'd5) ? 5 : int'(coarse);
      s = m_acc + int'(trim_code);
      c = s >> 8;
      m_acc = s & 255;
      last_trim = c;
      m = 6'((1 << k) - 1) | 6'(c << 5);
      half(b);
      chk(swap == 1'b1, "R2", {tag, " swap h1"}, swap, 1);
      chk(mux_sel == 2'd1, "R5", {tag, " sel h1"}, mux_sel, 1);
      chk(src_left[4:0] == m[4:0], "R6", {tag, " static h1"}, src_left, m);
      chk(src_left[5] == m[5] && trim_bit == c[0], "R7", {tag, " trim h1"},
          {src_left[5], trim_bit}, {m[5], c[0]});
      chk(src_right == 6'd0, "R5", {tag, " idle side h1"}, src_right, 0);
      half(b2);
      chk(mux_sel == 2'd2, "R9", {tag, " sel h2"}, mux_sel, 2);
      chk(src_right == m && src_left == 6'd0, "R5", {tag, " right h2"},
          {src_left, src_right}, {6'd0, m});
      chk(trim_bit == c[0], "R7", {tag, " trim h2"}, trim_bit, c);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    tick = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_ptr = 0;
    m_acc = 0;
  endtask

  task automatic test_reset();
    do_reset();
    chk(src_left == 0 && src_right == 0, "R1", "enables", {src_left, src_right}, 0);
    chk(swap == 0 && mux_sel == 0 && trim_bit == 0, "R1", "controls",
        {swap, mux_sel, trim_bit}, 0);
  endtask

  task automatic test_rotation();
    bit seen [6];
    do_reset();
    foreach (seen[i]) seen[i] = 1'b0;
    for (int n = 0; n < 6; n++) begin
      run_cycle(1'b0, 1'b0, "rot");
      seen[last_unit] = 1'b1;
    end
    for (int i = 0; i < 6; i++) chk(seen[i], "R4", "unit once per six", seen[i], 1);
    // one-cycles between zero-cycles must not move the index
    coarse = 3'd2;
    for (int n = 0; n < 8; n++) begin
      run_cycle(1'b1, 1'b1, "hold");
      run_cycle(1'b0, 1'b0, "R4 step");
    end
  endtask

  task automatic test_coarse();
    do_reset();
    trim_code = 8'd0;
    for (int c = 0; c < 8; c++) begin
      coarse = 3'(c);
      run_cycle(1'b1, 1'b1, "R6 sweep");
    end
  endtask

  task automatic test_duty(input logic [7:0] code);
    int ones = 0;
    do_reset();
    coarse = 3'd3;
    trim_code = code;
    for (int n = 0; n < 256; n++) begin
      run_cycle(1'b1, 1'b1, "R7 duty");
      ones += last_trim;
    end
    chk(ones == int'(code), "R7", "duty over 256", ones, code);
  endtask

  task automatic test_freeze();
    int ones = 0;
    do_reset();
    coarse = 3'd5;
    trim_code = 8'd93;
    for (int n = 0; n < 256; n++) begin
      run_cycle(1'b1, 1'b1, "R8 run");
      ones += last_trim;
      if (n % 3 == 0) begin
        run_cycle(1'b0, 1'b0, "R8 gap");
        run_cycle(1'b0, 1'b1, "R8 gap");
      end
    end
    chk(ones == 93, "R8", "duty with gaps", ones, 93);
  endtask

  task automatic test_mid_sample();
    do_reset();
    coarse = 3'd1;
    trim_code = 8'd200;
    for (int n = 0; n < 6; n++) begin
      run_cycle(1'b0, 1'b1, "R9 zero");
      run_cycle(1'b1, 1'b0, "R9 one");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    test_reset();
    test_rotation();
    test_coarse();
    test_duty(8'd0);
    test_duty(8'd77);
    test_duty(8'd255);
    test_freeze();
    test_mid_sample();
    summary();
  end
endmodule